// File: doc/BRIEF.md
# Parallel Bus Initiator Sequencer

This block is the master-side sequencer for a 32-bit bus that carries address and data on the same lines. A local client hands it one request: a start address, a command code, byte enables, a burst length and a source of write words. The block runs the address phase and the data phases that follow. It drives the frame, initiator-ready, address/data and command/byte-enable lines, and it watches the target's ready, device-select and stop responses.

Each request finishes in one of three ways. It can complete normally, or end in a master abort when no target claims it in time, or end early because the target signals stop. After the final phase the block drives both sustained control lines high for one cycle and then releases them. The local side receives every read word, a one-cycle done pulse, a completion code and the number of words that actually moved. Whenever the bus is idle and the grant is held, the block parks the address/data and command lines at a defined level. Every line has its own output enable, so a bench or the chip top can build a shared, pulled-up bus.

Top module: `bus_initiator_seq`

## Requirements
- R1: After synchronous reset with grant deasserted (gnt_n high), every output enable is low, done and rd_valid are low, status is 00 and xfer_count is 0.
- R2: req_ready is high only while idle with gnt_n low. A request accepted at an edge makes the next cycle the address phase: frame_n_o low, irdy_n_o high, both enabled; ad_o equals the address and cbe_o equals the command, both enabled.
- R3: In every data phase irdy_n_o is low and cbe_o carries the byte enables. wr_idx equals the number of words already transferred. A write is a command with bit 0 set: for a write, ad_o carries wr_data with ad_oe high. For a read, ad_oe is low.
- R4: A word transfers at a rising edge in a data phase where trdy_n_i and devsel_n_i are both low. xfer_count counts these words. For a read, rd_valid is high in the following cycle, with rd_data equal to the ad_i value sampled at that edge.
- R5: Once irdy_n_o is low, it stays low until a transfer, a stop or a master abort ends the data phase.
- R6: frame_n_o is high, with irdy_n_o low, in the data phase of the final requested word (a req_len of 0 counts as 1). It is low in all earlier data phases.
- R7: The cycle after the request ends is a release cycle. In it, frame_n_o and irdy_n_o are driven high, ad_oe and cbe_oe are low, and done is high. The next cycle has frame_oe and irdy_oe low. A normal completion reports status 00 and xfer_count equal to the length.
- R8: If devsel_n_i is not sampled low at any edge up to the fifth edge counted from the address phase, the release cycle comes five cycles after the address phase. It reports status 01 (master abort) with xfer_count 0. Device select first sampled low at the fifth edge prevents the abort.
- R9: stop_n_i sampled low in a data phase ends the request with status 10 (target stop). A word is counted if trdy_n_i was also low. If that word was the final requested one, the status is 00.
- R10: While idle with gnt_n low, ad_o and cbe_o are driven to 0 with their enables high. With gnt_n high, both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Start address |
| req_cmd | input | 4 | Command code, bit 0 set means write |
| req_be | input | 4 | Byte enables for all data phases |
| req_len | input | LEN_W | Number of words (0 counts as 1) |
| wr_data | input | 32 | Write word selected by wr_idx |
| wr_idx | output | LEN_W | Index of the write word wanted |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| done | output | 1 | Release cycle of a finished request |
| status | output | 2 | 00 normal, 01 master abort, 10 target stop |
| xfer_count | output | LEN_W | Words transferred by the current or last request |
| gnt_n | input | 1 | Bus grant, active low |
| ad_o | output | 32 | Address/data drive value |
| ad_oe | output | 1 | Address/data drive enable |
| ad_i | input | 32 | Address/data bus value |
| cbe_o | output | 4 | Command/byte-enable drive value |
| cbe_oe | output | 1 | Command/byte-enable drive enable |
| frame_n_o | output | 1 | Frame drive value, active low |
| frame_oe | output | 1 | Frame drive enable |
| irdy_n_o | output | 1 | Initiator ready drive value, active low |
| irdy_oe | output | 1 | Initiator ready drive enable |
| trdy_n_i | input | 1 | Target ready, active low |
| devsel_n_i | input | 1 | Device select, active low |
| stop_n_i | input | 1 | Target stop, active low |

## Verification
The bench builds the block with LEN_W = 4 and the default device-select limit of 5. The small length field keeps bursts short enough to walk every word. The default limit is the one the abort timing rule is written against. The limit lets the bench place device select exactly on the fifth edge, and also leave it off entirely, to test both sides of the abort boundary. A scripted target adds wait states and stops with and without data, including a stop on the final word.

// File: rtl/bis_pkg.sv
package bis_pkg;

    parameter int AD_W  = 32;
    parameter int CBE_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_REL  = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        CS_NORMAL = 2'b00,
        CS_MABORT = 2'b01,
        CS_TSTOP  = 2'b10
    } cstat_t;

    typedef struct packed {
        logic [AD_W-1:0]  addr;
        logic [CBE_W-1:0] cmd;
        logic [CBE_W-1:0] be;
    } req_hdr_t;

    typedef struct packed {
        logic             frame_n;
        logic             frame_oe;
        logic             irdy_n;
        logic             irdy_oe;
        logic             ad_oe;
        logic             cbe_oe;
        logic [AD_W-1:0]  ad;
        logic [CBE_W-1:0] cbe;
    } bus_drv_t;

    function automatic logic cmd_is_write(input logic [CBE_W-1:0] cmd);
        return cmd[0];
    endfunction

endpackage

// File: rtl/bis_devsel_timer.sv
module bis_devsel_timer #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic run,
    input  logic devsel_n,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] edges_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edges_q <= '0;
            seen_q  <= 1'b0;
        end else if (arm) begin
            edges_q <= CW'(1);
            seen_q  <= 1'b0;
        end else if (run) begin
            if (edges_q != CW'(LIMIT)) begin
                edges_q <= edges_q + 1'b1;
            end
            if (!devsel_n) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign expire = run && !seen_q && devsel_n && (edges_q == CW'(LIMIT - 1));

endmodule

// File: rtl/bis_bus_drive.sv
module bis_bus_drive
    import bis_pkg::*;
(
    input  phase_t          phase,
    input  req_hdr_t        hdr,
    input  logic            last_beat,
    input  logic [AD_W-1:0] wr_data,
    input  logic            gnt_n,
    output bus_drv_t        drv
);
    always_comb begin
        drv         = '0;
        drv.frame_n = 1'b1;
        drv.irdy_n  = 1'b1;
        unique case (phase)
            PH_IDLE: begin
                drv.ad_oe  = !gnt_n;
                drv.cbe_oe = !gnt_n;
            end
            PH_ADDR: begin
                drv.frame_oe = 1'b1;
                drv.frame_n  = 1'b0;
                drv.irdy_oe  = 1'b1;
                drv.ad_oe    = 1'b1;
                drv.ad       = hdr.addr;
                drv.cbe_oe   = 1'b1;
                drv.cbe      = hdr.cmd;
            end
            PH_DATA: begin
                drv.frame_oe = 1'b1;
                drv.frame_n  = last_beat;
                drv.irdy_oe  = 1'b1;
                drv.irdy_n   = 1'b0;
                drv.cbe_oe   = 1'b1;
                drv.cbe      = hdr.be;
                if (cmd_is_write(hdr.cmd)) begin
                    drv.ad_oe = 1'b1;
                    drv.ad    = wr_data;
                end
            end
            PH_REL: begin
                drv.frame_oe = 1'b1;
                drv.irdy_oe  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_initiator_seq.sv
module bus_initiator_seq
    import bis_pkg::*;
#(
    parameter int LEN_W        = 8,
    parameter int DEVSEL_LIMIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AD_W-1:0]   req_addr,
    input  logic [CBE_W-1:0]  req_cmd,
    input  logic [CBE_W-1:0]  req_be,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [AD_W-1:0]   wr_data,
    output logic [LEN_W-1:0]  wr_idx,
    output logic              rd_valid,
    output logic [AD_W-1:0]   rd_data,
    output logic              done,
    output logic [1:0]        status,
    output logic [LEN_W-1:0]  xfer_count,
    input  logic              gnt_n,
    output logic [AD_W-1:0]   ad_o,
    output logic              ad_oe,
    input  logic [AD_W-1:0]   ad_i,
    output logic [CBE_W-1:0]  cbe_o,
    output logic              cbe_oe,
    output logic              frame_n_o,
    output logic              frame_oe,
    output logic              irdy_n_o,
    output logic              irdy_oe,
    input  logic              trdy_n_i,
    input  logic              devsel_n_i,
    input  logic              stop_n_i
);
    phase_t           phase_q;
    req_hdr_t         hdr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    cstat_t           status_q;
    logic             rd_valid_q;
    logic [AD_W-1:0]  rd_data_q;
    logic             last_beat;
    logic             beat_done;
    logic             timed_out;
    bus_drv_t         drv;

    assign req_ready = (phase_q == PH_IDLE) && !gnt_n;
    assign last_beat = (len_q - cnt_q) == LEN_W'(1);
    assign beat_done = (phase_q == PH_DATA) && !trdy_n_i && !devsel_n_i;

    bis_devsel_timer #(.LIMIT(DEVSEL_LIMIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .arm      (phase_q == PH_ADDR),
        .run      (phase_q == PH_DATA),
        .devsel_n (devsel_n_i),
        .expire   (timed_out)
    );

    bis_bus_drive u_drive (
        .phase     (phase_q),
        .hdr       (hdr_q),
        .last_beat (last_beat),
        .wr_data   (wr_data),
        .gnt_n     (gnt_n),
        .drv       (drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            hdr_q      <= '0;
            len_q      <= LEN_W'(1);
            cnt_q      <= '0;
            status_q   <= CS_NORMAL;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid && req_ready) begin
                        hdr_q   <= '{addr: req_addr, cmd: req_cmd, be: req_be};
                        len_q   <= (req_len == '0) ? LEN_W'(1) : req_len;
                        cnt_q   <= '0;
                        phase_q <= PH_ADDR;
                    end
                end
                PH_ADDR: phase_q <= PH_DATA;
                PH_DATA: begin
                    if (beat_done) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (!cmd_is_write(hdr_q.cmd)) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= ad_i;
                        end
                        if (last_beat) begin
                            status_q <= CS_NORMAL;
                            phase_q  <= PH_REL;
                        end else if (!stop_n_i) begin
                            status_q <= CS_TSTOP;
                            phase_q  <= PH_REL;
                        end
                    end else if (!stop_n_i) begin
                        status_q <= CS_TSTOP;
                        phase_q  <= PH_REL;
                    end else if (timed_out) begin
                        status_q <= CS_MABORT;
                        phase_q  <= PH_REL;
                    end
                end
                PH_REL:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign wr_idx     = cnt_q;
    assign xfer_count = cnt_q;
    assign rd_valid   = rd_valid_q;
    assign rd_data    = rd_data_q;
    assign done       = (phase_q == PH_REL);
    assign status     = status_q;
    assign ad_o       = drv.ad;
    assign ad_oe      = drv.ad_oe;
    assign cbe_o      = drv.cbe;
    assign cbe_oe     = drv.cbe_oe;
    assign frame_n_o  = drv.frame_n;
    assign frame_oe   = drv.frame_oe;
    assign irdy_n_o   = drv.irdy_n;
    assign irdy_oe    = drv.irdy_oe;

endmodule

// File: rtl/bus_initiator_seq_chk.sv
module bus_initiator_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             gnt_n,
    input logic             rd_valid,
    input logic             done,
    input logic [1:0]       status,
    input logic [LEN_W-1:0] xfer_count,
    input logic             ad_oe,
    input logic             cbe_oe,
    input logic             frame_n_o,
    input logic             frame_oe,
    input logic             irdy_n_o,
    input logic             irdy_oe,
    input logic             trdy_n_i,
    input logic             devsel_n_i,
    input logic             stop_n_i
);
    assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!gnt_n && !frame_oe && !irdy_oe));

    assert_read_after_beat_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(irdy_oe && !irdy_n_o && !trdy_n_i && !devsel_n_i));

    assert_irdy_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (irdy_oe && !irdy_n_o && trdy_n_i && stop_n_i && !devsel_n_i) |=> (irdy_oe && !irdy_n_o));

    assert_frame_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_oe && !frame_n_o) |=> frame_oe);

    assert_irdy_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (irdy_oe && !irdy_n_o) |=> irdy_oe);

    assert_release_high_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_oe && frame_n_o && irdy_oe && irdy_n_o && !ad_oe && !cbe_oe));

    assert_abort_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (done && status == 2'b01) |-> (xfer_count == '0));

    assert_park_R10: assert property (@(posedge clk) disable iff (rst)
        (!frame_oe && !irdy_oe && !gnt_n) |-> (ad_oe && cbe_oe));
endmodule

bind bus_initiator_seq bus_initiator_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .gnt_n      (gnt_n),
    .rd_valid   (rd_valid),
    .done       (done),
    .status     (status),
    .xfer_count (xfer_count),
    .ad_oe      (ad_oe),
    .cbe_oe     (cbe_oe),
    .frame_n_o  (frame_n_o),
    .frame_oe   (frame_oe),
    .irdy_n_o   (irdy_n_o),
    .irdy_oe    (irdy_oe),
    .trdy_n_i   (trdy_n_i),
    .devsel_n_i (devsel_n_i),
    .stop_n_i   (stop_n_i)
);

// File: tb/bus_initiator_seq_tb.sv
module bus_initiator_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic [3:0]       req_cmd = '0;
    logic [3:0]       req_be = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [31:0]      wr_data;
    logic [LEN_W-1:0] wr_idx;
    logic             rd_valid;
    logic [31:0]      rd_data;
    logic             done;
    logic [1:0]       status;
    logic [LEN_W-1:0] xfer_count;
    logic             gnt_n = 1'b1;
    logic [31:0]      ad_o;
    logic             ad_oe;
    logic [31:0]      ad_i;
    logic [3:0]       cbe_o;
    logic             cbe_oe;
    logic             frame_n_o, frame_oe, irdy_n_o, irdy_oe;
    logic             trdy_n_i, devsel_n_i, stop_n_i;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    // scripted target
    int   t_dly   = 0;
    int   t_tw    = 0;
    int   t_stopw = -1;
    bit   t_stopd = 0;
    int   dcyc    = 0;
    int   twords  = 0;
    logic [31:0] t_wbase = 32'hD000_0000;

    wire in_data  = irdy_oe && !irdy_n_o;
    wire dev_on   = in_data && (t_dly != 0) && ((dcyc + 1) >= t_dly);
    wire rdy_time = dev_on && ((dcyc + 1) >= (t_dly + t_tw));
    wire stop_on  = rdy_time && (twords == t_stopw);
    wire trdy_on  = rdy_time && !(stop_on && !t_stopd);

    assign devsel_n_i = !dev_on;
    assign trdy_n_i   = !trdy_on;
    assign stop_n_i   = !stop_on;
    assign ad_i       = 32'hA000_0000 + 32'(twords);
    assign wr_data    = t_wbase + 32'(wr_idx);

    always @(posedge clk) begin
        dcyc   <= in_data ? dcyc + 1 : 0;
        twords <= !frame_oe ? 0 : (in_data && trdy_on && dev_on) ? twords + 1 : twords;
    end

    bus_initiator_seq #(.LEN_W(LEN_W)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          m_ph = 0;
    int          m_cnt = 0, m_len = 1, m_edge = 0, m_st = 0;
    bit          m_seen = 0, m_rdv = 0, m_wr = 0;
    logic [31:0] m_addr = '0, m_rdd = '0;
    logic [3:0]  m_cmd = '0, m_be = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_st = 0; m_rdv = 0; m_len = 1;
        end else begin
            m_rdv = 0;
            case (m_ph)
                0: if (req_valid && !gnt_n) begin
                    m_ph = 1; m_addr = req_addr; m_cmd = req_cmd; m_be = req_be;
                    m_len = (req_len == 0) ? 1 : int'(req_len); m_cnt = 0; m_wr = req_cmd[0];
                end
                1: begin m_ph = 2; m_edge = 1; m_seen = 0; end
                2: begin
                    m_edge++;
                    if (!trdy_n_i && !devsel_n_i) begin
                        m_cnt++;
                        if (!m_wr) begin m_rdv = 1; m_rdd = ad_i; end
                        if (m_cnt == m_len) begin m_st = 0; m_ph = 3; end
                        else if (!stop_n_i) begin m_st = 2; m_ph = 3; end
                    end else if (!stop_n_i) begin
                        m_st = 2; m_ph = 3;
                    end else if (devsel_n_i && !m_seen && m_edge == 5) begin
                        m_st = 1; m_ph = 3;
                    end
                    if (!devsel_n_i) m_seen = 1;
                end
                default: m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            case (m_ph)
                0: begin
                    chk("R10 ad_oe", ad_oe, !gnt_n);
                    chk("R10 cbe_oe", cbe_oe, !gnt_n);
                    if (!gnt_n) begin chk("R10 ad_o", ad_o, 0); chk("R10 cbe_o", cbe_o, 0); end
                    chk("R7 frame_oe", frame_oe, 0);
                    chk("R7 irdy_oe", irdy_oe, 0);
                    chk("R2 req_ready", req_ready, !gnt_n);
                end
                1: begin
                    chk("R2 frame", {frame_oe, frame_n_o, irdy_oe, irdy_n_o}, 4'b1011);
                    chk("R2 ad_oe", ad_oe, 1); chk("R2 ad_o", ad_o, m_addr);
                    chk("R2 cbe_oe", cbe_oe, 1); chk("R2 cbe_o", cbe_o, m_cmd);
                    chk("R2 req_ready", req_ready, 0);
                end
                2: begin
                    chk("R5 irdy", {irdy_oe, irdy_n_o}, 2'b10);
                    chk("R6 frame", {frame_oe, frame_n_o}, {1'b1, (m_len - m_cnt == 1)});
                    chk("R3 cbe", {cbe_oe, cbe_o}, {1'b1, m_be});
                    chk("R3 ad_oe", ad_oe, m_wr);
                    if (m_wr) chk("R3 ad_o", ad_o, t_wbase + 32'(m_cnt));
                end
                default: begin
                    chk("R7 release", {frame_oe, frame_n_o, irdy_oe, irdy_n_o, ad_oe, cbe_oe}, 6'b111100);
                end
            endcase
            chk("R7 done", done, m_ph == 3);
            chk("R7 status", status, m_st);
            chk("R4 xfer_count", xfer_count, m_cnt);
            chk("R3 wr_idx", wr_idx, m_cnt);
            chk("R4 rd_valid", rd_valid, m_rdv);
            if (m_rdv) chk("R4 rd_data", rd_data, m_rdd);
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected<=20000", cyc);
            finish_run();
        end
    end

    task automatic run_txn(input string tag, input logic [31:0] a, input logic [3:0] c,
                           input logic [3:0] b, input int len, input int dly, input int tw,
                           input int stopw, input bit stopd, input int exp_st,
                           input int exp_cnt, input int exp_lat);
        int n;
        t_dly = dly; t_tw = tw; t_stopw = stopw; t_stopd = stopd;
        t_wbase = 32'hD000_0000 + {a[15:0], 16'h0};
        req_addr = a; req_cmd = c; req_be = b; req_len = LEN_W'(len);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        n = 1;
        @(negedge clk);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done seen"}, done, 1);
        chk({tag, " status"}, status, exp_st);
        chk({tag, " count"}, xfer_count, exp_cnt);
        if (exp_lat > 0) chk({tag, " release latency"}, n, exp_lat);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 oe", {ad_oe, cbe_oe, frame_oe, irdy_oe}, 4'b0000);
        chk("R1 done/rd_valid", {done, rd_valid}, 2'b00);
        chk("R1 status", status, 0);
        chk("R1 count", xfer_count, 0);
        @(posedge clk); #1 gnt_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 gnt_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 gnt_n = 1'b0;
        @(posedge clk); #1;
        run_txn("R7 write burst", 32'h0000_1000, 4'h7, 4'hF, 4, 1, 0, -1, 0, 0, 4, 0);
        run_txn("R4 read waits",  32'h0000_2000, 4'h6, 4'h3, 3, 2, 2, -1, 0, 0, 3, 0);
        run_txn("R6 single write",32'h0000_3000, 4'h7, 4'h1, 1, 3, 0, -1, 0, 0, 1, 0);
        run_txn("R8 master abort",32'h0000_4000, 4'h6, 4'hF, 2, 0, 0, -1, 0, 1, 0, 6);
        run_txn("R8 select at edge 5", 32'h0000_5000, 4'h6, 4'hF, 2, 4, 0, -1, 0, 0, 2, 0);
        run_txn("R9 stop with data",   32'h0000_6000, 4'h7, 4'hC, 5, 1, 1, 2, 1, 2, 3, 0);
        run_txn("R9 stop no data",     32'h0000_7000, 4'h6, 4'hF, 3, 1, 0, 0, 0, 2, 0, 0);
        run_txn("R9 stop on last",     32'h0000_8000, 4'h6, 4'hF, 3, 1, 0, 2, 1, 0, 3, 0);
        run_txn("R5 write waits",      32'h0000_9000, 4'h7, 4'h5, 2, 2, 3, -1, 0, 0, 2, 0);
        #1 gnt_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end
endmodule